// File: doc/BRIEF.md
# Command Ring Fetch Engine

This block is the controller half of a command queue that software keeps in system memory as a circular array of 32-bit words. Software programs a 64-bit ring base, picks a ring length with a size code, and advances a write pointer after it stores new commands. The block owns a read pointer. While fetching is enabled and the read pointer trails the write pointer, the block reads the next word from memory and hands it to a downstream codec link port.

The memory side is a single-outstanding request/response port. The link side is a valid/ready stream with the usual back-pressure rules. `cmd_valid` rises only when a fetched word is ready. It stays high, with `cmd_data` and `cmd_codec` unchanged, until `cmd_ready` is sampled high on a clock edge. No further memory request is issued while a command is waiting.

Software gets a two-step handshake to reset the read pointer and a run bit that reports a stop only once the current fetch has fully drained. A power-down input hides the pointers and keeps new fetches from starting.

Top module: `cmd_ring_engine`

## Requirements
- R1: After reset, both pointer registers and the control register read 0, `ring_full` is 0, and neither `mem_req_valid` nor `cmd_valid` is asserted.
- R2: The first command of a pass is fetched from slot 1. Each following command comes from slot (read pointer + 1) mod entries. The read pointer takes the value of that slot on the clock edge where the command is accepted downstream, and it changes on no other edge except a pointer reset.
- R3: The size register (offset 2, bits [1:0]) selects the ring length: code 0 gives 2 entries, code 1 gives 16, and codes 2 and 3 give 256. A write-pointer value is masked to the ring length when it is written. On passes after the first, slot 0 is fetched in its turn.
- R4: No fetch starts while the read pointer equals the write pointer. Fetching continues until they are equal.
- R5: The memory address is {base high (offset 1), base low (offset 0)} + 4 × slot. The returned word is forwarded unchanged on `cmd_data`, and `cmd_codec` carries bits [31:28] of that word.
- R6: Writing the read-pointer register (offset 5) with bit 15 set clears the read pointer. The register then reads 0x8000, and fetching is held off. A later write with bit 15 clear releases the hold, and the register then reads 0. The other bits written to this register are ignored.
- R7: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and `cmd_data` stays stable. No memory request is presented while a command is waiting.
- R8: The run bit is bit 0 of the control register (offset 3). Clearing it stops new fetches. It reads back 1 until the in-flight fetch has been accepted downstream, then reads 0.
- R9: While `pwr_down` is high, both pointer registers (offsets 4 and 5) read 0x0000FFFF and no new fetch starts. When `pwr_down` falls, fetching resumes.
- R10: `ring_full` is 1 exactly when ((write pointer + 1) mod entries) equals the read pointer.
- R11: `mem_req_valid` first rises in the cycle after the clock edge that writes the enabling register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for both writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| pwr_down | input | 1 | Hides the pointers and suppresses new fetches |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | 64 | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | 32 | Memory read data |
| cmd_valid | output | 1 | Command available to the link port |
| cmd_ready | input | 1 | Link port accepts the command |
| cmd_data | output | 32 | Command word |
| cmd_codec | output | 4 | Target codec field of the command word |
| ring_full | output | 1 | Ring full from the software point of view |

## Verification
Register writes take effect on the clock edge of the write and are visible on `reg_rdata` at the next falling edge. A memory request appears one cycle after the enabling write. The read pointer moves on the edge that accepts a command. The run readback falls one cycle after that final acceptance.

The bench drives every input and samples every output on the falling edge. It checks the one-cycle request latency at exactly the following two falling edges. For other results it waits for the handshake event and then samples a fixed number of falling edges later, so each read lands in a cycle where the result is already due and stable.

Expected command words come from an arithmetic function of the address formula. The bench applies the same function inside its own memory model. Sweeps run over all three ring lengths, through full wraps, and under stalls on the link side and the memory side.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;
  typedef enum logic [1:0] {FS_IDLE, FS_REQ, FS_WAIT, FS_SEND} fetch_state_e;

  localparam int REG_AW       = 3;
  localparam int REG_DW       = 32;
  localparam int MEM_AW       = 64;
  localparam int RST_BIT      = 15;

  localparam logic [REG_AW-1:0] RA_BASE_LO = 3'd0;
  localparam logic [REG_AW-1:0] RA_BASE_HI = 3'd1;
  localparam logic [REG_AW-1:0] RA_SIZE    = 3'd2;
  localparam logic [REG_AW-1:0] RA_CTRL    = 3'd3;
  localparam logic [REG_AW-1:0] RA_WPTR    = 3'd4;
  localparam logic [REG_AW-1:0] RA_RPTR    = 3'd5;

  localparam logic [REG_DW-1:0] PTR_HIDDEN = 32'h0000_FFFF;
endpackage

// File: rtl/cmd_ring_regs.sv
module cmd_ring_regs
  import cmd_ring_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [REG_DW-1:0]    reg_wdata,
  output logic [REG_DW-1:0]    reg_rdata,
  input  logic                 pwr_down,
  input  logic [PTR_W-1:0]     rp,
  input  logic                 busy,
  output logic [MEM_AW-1:0]    base,
  output logic [PTR_W-1:0]     wp,
  output logic [PTR_W-1:0]     mask,
  output logic                 run,
  output logic                 rp_hold,
  output logic                 rp_clr,
  output logic                 ring_full
);
  localparam int HALF_AW = MEM_AW / 2;

  logic [HALF_AW-1:0] base_lo_q, base_hi_q;
  logic [1:0]         size_q;
  logic [PTR_W-1:0]   wp_q;
  logic               run_q, hold_q;

  // ring length from the size code; codes above 1 select the full pointer range
  always_comb begin
    case (size_q)
      2'd0:    mask = PTR_W'(1);
      2'd1:    mask = PTR_W'(15);
      default: mask = '1;
    endcase
  end

  assign rp_clr    = reg_we && (reg_addr == RA_RPTR) && reg_wdata[RST_BIT];
  assign base      = {base_hi_q, base_lo_q};
  assign wp        = wp_q;
  assign run       = run_q;
  assign rp_hold   = hold_q;
  assign ring_full = (PTR_W'(wp_q + 1'b1) & mask) == rp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_lo_q <= '0;
      base_hi_q <= '0;
      size_q    <= '0;
      wp_q      <= '0;
      run_q     <= 1'b0;
      hold_q    <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        RA_BASE_LO: base_lo_q <= reg_wdata;
        RA_BASE_HI: base_hi_q <= reg_wdata;
        RA_SIZE:    size_q    <= reg_wdata[1:0];
        RA_CTRL:    run_q     <= reg_wdata[0];
        RA_WPTR:    wp_q      <= reg_wdata[PTR_W-1:0] & mask;
        RA_RPTR:    hold_q    <= reg_wdata[RST_BIT];
        default:    ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_BASE_LO: reg_rdata = base_lo_q;
      RA_BASE_HI: reg_rdata = base_hi_q;
      RA_SIZE:    reg_rdata = REG_DW'(size_q);
      RA_CTRL:    reg_rdata = REG_DW'(run_q | busy);
      RA_WPTR:    reg_rdata = pwr_down ? PTR_HIDDEN : REG_DW'(wp_q);
      RA_RPTR:    reg_rdata = pwr_down ? PTR_HIDDEN
                            : (REG_DW'(rp) | (REG_DW'(hold_q) << RST_BIT));
      default:    reg_rdata = '0;
    endcase
  end

  // R6: the fetch side must honour a pointer reset on the very next edge
  a_r6_rp_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rp_clr |=> (rp == '0));
endmodule

// File: rtl/cmd_ring_fetch_fsm.sv
module cmd_ring_fetch_fsm
  import cmd_ring_pkg::*;
#(
  parameter int PTR_W = 8,
  parameter int CMD_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               rp_hold,
  input  logic               rp_clr,
  input  logic               pwr_down,
  input  logic [MEM_AW-1:0]  base,
  input  logic [PTR_W-1:0]   wp,
  input  logic [PTR_W-1:0]   mask,
  output logic [PTR_W-1:0]   rp,
  output logic               busy,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [MEM_AW-1:0]  mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [CMD_W-1:0]   mem_rsp_data,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [CMD_W-1:0]   cmd_data
);
  localparam int BYTE_SH = $clog2(CMD_W / 8);

  fetch_state_e     state_q;
  logic [PTR_W-1:0] rp_q, slot;
  logic [CMD_W-1:0] cmd_q;
  logic             start;

  assign slot          = PTR_W'(rp_q + 1'b1) & mask;
  assign start         = run && !rp_hold && !pwr_down && (rp_q != wp);
  assign mem_req_valid = (state_q == FS_REQ);
  assign mem_req_addr  = base + (MEM_AW'(slot) << BYTE_SH);
  assign cmd_valid     = (state_q == FS_SEND);
  assign cmd_data      = cmd_q;
  assign busy          = (state_q != FS_IDLE);
  assign rp            = rp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      rp_q    <= '0;
      cmd_q   <= '0;
    end else begin
      if (rp_clr)
        rp_q <= '0;
      else if (state_q == FS_SEND && cmd_ready)
        rp_q <= slot;
      case (state_q)
        FS_IDLE: if (start) state_q <= FS_REQ;
        FS_REQ:  if (mem_req_ready) state_q <= FS_WAIT;
        FS_WAIT: if (mem_rsp_valid) begin
          cmd_q   <= mem_rsp_data;
          state_q <= FS_SEND;
        end
        FS_SEND: if (cmd_ready) state_q <= FS_IDLE;
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  // R4: a request is never made for the slot software has not yet filled
  a_r4_no_fetch_past_wp: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (rp != wp));
  // R7: a stalled command holds still
  a_r7_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));
  // R2: read pointer moves only on a downstream accept or a reset
  a_r2_rp_moves_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cmd_valid && cmd_ready) && !rp_clr) |=> $stable(rp));
  // R9: no fetch begins while powered down
  a_r9_no_start_in_pwrdn: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> !$past(pwr_down));
endmodule

// File: rtl/cmd_ring_engine.sv
module cmd_ring_engine
  import cmd_ring_pkg::*;
#(
  parameter int PTR_W   = 8,
  parameter int CMD_W   = 32,
  parameter int CODEC_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [2:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 pwr_down,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [63:0]          mem_req_addr,
  input  logic                 mem_rsp_valid,
  input  logic [CMD_W-1:0]     mem_rsp_data,
  output logic                 cmd_valid,
  input  logic                 cmd_ready,
  output logic [CMD_W-1:0]     cmd_data,
  output logic [CODEC_W-1:0]   cmd_codec,
  output logic                 ring_full
);
  logic [MEM_AW-1:0] base;
  logic [PTR_W-1:0]  wp, rp, mask;
  logic              run, rp_hold, rp_clr, busy;

  cmd_ring_regs #(.PTR_W(PTR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwr_down(pwr_down),
    .rp(rp), .busy(busy), .base(base), .wp(wp), .mask(mask), .run(run),
    .rp_hold(rp_hold), .rp_clr(rp_clr), .ring_full(ring_full)
  );

  cmd_ring_fetch_fsm #(.PTR_W(PTR_W), .CMD_W(CMD_W)) fetch_i (
    .clk(clk), .rst_n(rst_n), .run(run), .rp_hold(rp_hold), .rp_clr(rp_clr),
    .pwr_down(pwr_down), .base(base), .wp(wp), .mask(mask), .rp(rp),
    .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data)
  );

  assign cmd_codec = cmd_data[CMD_W-1 -: CODEC_W];
endmodule

// File: tb/cmd_ring_engine_tb_top.sv
`timescale 1ns/1ps
module cmd_ring_engine_tb_top;
  localparam logic [63:0] BASE = 64'h0000_0001_0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic pwr_down = 1'b0;
  logic mem_req_valid, mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic cmd_valid, cmd_ready = 1'b0;
  logic [31:0] cmd_data;
  logic [3:0] cmd_codec;
  logic ring_full;

  always #2 clk = ~clk;

  cmd_ring_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwr_down(pwr_down),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .cmd_codec(cmd_codec), .ring_full(ring_full)
  );

  int total = 0, bad = 0;
  int ngot = 0, hold_viol = 0, overlap = 0;
  int ready_mode = 0, lat = 0, cd = 0, cyc = 0;
  bit pend = 0, prev_hold = 0, done = 0;
  logic [63:0] paddr;
  logic [31:0] prev_data;
  logic [31:0] got [0:1023];
  logic [3:0]  got_codec [0:1023];

  function automatic logic [31:0] fword(input logic [63:0] a);
    fword = (a[31:0] * 32'h9E37_79B1) ^ a[63:32] ^ 32'h1357_2468;
  endfunction

  // memory model and link-side sink, all on the falling edge
  always @(negedge clk) begin
    bit r;
    cyc++;
    if (mem_rsp_valid) mem_rsp_valid = 1'b0;
    if (pend) begin
      if (cd == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = fword(paddr);
        pend = 0;
      end else cd--;
    end
    mem_req_ready = !pend && (ready_mode != 1 || cyc[0]);
    if (mem_req_valid && mem_req_ready) begin
      pend = 1; paddr = mem_req_addr; cd = lat;
    end
    r = (ready_mode == 0) ? 1'b1 : cyc[1];
    if (prev_hold && (!cmd_valid || cmd_data != prev_data)) hold_viol++;
    if (mem_req_valid && cmd_valid) overlap++;
    prev_hold = cmd_valid && !r;
    prev_data = cmd_data;
    cmd_ready = r;
    if (cmd_valid && r && ngot < 1024) begin
      got[ngot] = cmd_data;
      got_codec[ngot] = cmd_codec;
      ngot++;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_cmds(input int target, input string tag);
    int n = 0;
    while (ngot < target && n < 5000) begin @(negedge clk); n++; end
    chk(tag, 64'(ngot), 64'(target));
    repeat (2) @(negedge clk);
  endtask

  task automatic no_req(input int n, input string tag);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mem_req_valid) seen = 1;
    end
    chk(tag, 64'(seen), 64'd0);
  endtask

  // compare n recorded commands starting at index st against slots first..
  task automatic chk_cmds(input int st, input int n, input int first,
                          input int msk, input string tag);
    int errs = 0;
    for (int i = 0; i < n; i++) begin
      logic [63:0] a = BASE + 64'(((first + i) & msk) * 4);
      if (got[st+i] !== fword(a) || got_codec[st+i] !== fword(a)[31:28]) begin
        if (errs == 0)
          $display("FAIL %s idx=%0d act=%h exp=%h", tag, i, got[st+i], fword(a));
        errs++;
      end
    end
    total++;
    if (errs != 0) bad++;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    int st;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd5, d); chk("R1 rptr", d, 0);
    rd(3'd4, d); chk("R1 wptr", d, 0);
    rd(3'd3, d); chk("R1 ctrl", d, 0);
    chk("R1 full", ring_full, 0);
    chk("R1 outputs", {mem_req_valid, cmd_valid}, 0);

    // R5/R2/R11 first pass, 256-entry ring
    wr(3'd0, BASE[31:0]); wr(3'd1, BASE[63:32]); wr(3'd2, 32'd2);
    wr(3'd4, 32'd5);
    chk("R10 not full", ring_full, 0);
    no_req(8, "R8 idle while run clear");
    st = ngot;
    wr(3'd3, 32'd1);
    chk("R11 no req at write edge", mem_req_valid, 0);
    @(negedge clk);
    chk("R11 req one cycle later", mem_req_valid, 1);
    wait_cmds(st + 5, "R2 count first pass");
    chk_cmds(st, 5, 1, 255, "R5 R2 slots 1..5");
    rd(3'd5, d); chk("R2 rptr after pass", d, 5);
    no_req(10, "R4 stop at wptr");

    // R7 back-pressure on both sides
    ready_mode = 1; lat = 3; st = ngot;
    wr(3'd4, 32'd20);
    wait_cmds(st + 15, "R7 count stalled");
    chk_cmds(st, 15, 6, 255, "R7 data under stalls");
    chk("R7 hold stable", 64'(hold_viol), 0);
    chk("R7 no req while cmd waits", 64'(overlap), 0);

    // R3 full wrap of 256-entry ring, slot 0 on second pass
    ready_mode = 0; lat = 0; st = ngot;
    wr(3'd4, 32'd255);
    wait_cmds(st + 235, "R3 count to 255");
    chk_cmds(st, 235, 21, 255, "R3 slots 21..255");
    st = ngot;
    wr(3'd4, 32'd2);
    wait_cmds(st + 3, "R3 count wrap");
    chk_cmds(st, 3, 0, 255, "R3 wrap slots 0..2");
    wr(3'd3, 32'd0);
    wr(3'd4, 32'd1);
    chk("R10 full 256", ring_full, 1);
    no_req(10, "R8 no fetch after stop");

    // R8 stop during an in-flight fetch
    lat = 40; st = ngot;
    wr(3'd3, 32'd1);
    while (!pend) @(negedge clk);
    wr(3'd3, 32'd0);
    rd(3'd3, d); chk("R8 run reads 1 while busy", d, 1);
    wait_cmds(st + 1, "R8 in-flight delivered");
    rd(3'd3, d); chk("R8 run reads 0 after drain", d, 0);
    rd(3'd5, d); chk("R8 rptr after drain", d, 3);
    no_req(20, "R8 nothing after drain");
    lat = 0;

    // R6 two-step read-pointer reset
    wr(3'd5, 32'h8000);
    rd(3'd5, d); chk("R6 ack reads 0x8000", d, 32'h8000);
    wr(3'd3, 32'd1);
    no_req(10, "R6 held during reset");
    st = ngot;
    wr(3'd5, 32'h0005);
    rd(3'd5, d); chk("R6 release reads 0", d, 0);
    wait_cmds(st + 1, "R6 fetch after release");
    chk_cmds(st, 1, 1, 255, "R6 slot 1 after reset");

    // R3 16-entry ring with masked write pointer
    wr(3'd3, 32'd0); wr(3'd2, 32'd1);
    wr(3'd5, 32'h8000); wr(3'd5, 32'h0);
    wr(3'd4, 32'd15); st = ngot;
    wr(3'd3, 32'd1);
    wait_cmds(st + 15, "R3 count 16-ring");
    chk_cmds(st, 15, 1, 15, "R3 16-ring slots 1..15");
    st = ngot;
    wr(3'd4, 32'h13);
    rd(3'd4, d); chk("R3 wptr masked", d, 3);
    wait_cmds(st + 4, "R3 count 16-ring wrap");
    chk_cmds(st, 4, 0, 15, "R3 16-ring wrap 0..3");

    // R3/R10 two-entry ring
    wr(3'd3, 32'd0); wr(3'd5, 32'h8000); wr(3'd5, 32'h0);
    wr(3'd2, 32'd0); wr(3'd4, 32'd1); st = ngot;
    wr(3'd3, 32'd1);
    wait_cmds(st + 1, "R3 2-ring first");
    wr(3'd4, 32'd0);
    wait_cmds(st + 2, "R3 2-ring second");
    wr(3'd4, 32'd1);
    wait_cmds(st + 3, "R3 2-ring third");
    chk_cmds(st, 3, 1, 1, "R3 2-ring slots 1,0,1");
    wr(3'd3, 32'd0); wr(3'd4, 32'd0);
    chk("R10 full 2-ring", ring_full, 1);

    // R9 power-down
    pwr_down = 1'b1; st = ngot;
    wr(3'd3, 32'd1);
    rd(3'd5, d); chk("R9 rptr hidden", d, 32'hFFFF);
    rd(3'd4, d); chk("R9 wptr hidden", d, 32'hFFFF);
    no_req(20, "R9 no fetch powered down");
    pwr_down = 1'b0;
    wait_cmds(st + 1, "R9 resume");
    chk_cmds(st, 1, 0, 1, "R9 slot 0 after resume");
    rd(3'd5, d); chk("R9 rptr visible again", d, 0);

    done = 1;
    finish_run();
  end
endmodule